// File: doc/BRIEF.md
# Atomic CSR Read-Modify-Write Unit

This unit executes control-and-status-register instructions at the commit stage of a simple in-order pipeline. Each instruction does one read-modify-write as a single step. The unit reads the old CSR value and returns it to the integer register file. In the same cycle it writes the modified value into a small local bank. The bank holds a status register, whose bit 1 is the interrupt enable, and a parameterised number of scratch registers. There are three operation kinds: swap, bit-set and bit-clear. Each kind takes its source either from a register value or from a zero-extended 5-bit immediate.

Because the read and the write happen in the same commit cycle, the unit needs no path that forwards CSR writes. An operation that writes both the integer destination and the CSR is a dual-destination operation, and it is not pipelined. It first drains the older in-flight instructions (pre-sync), then commits, and then runs a fixed post-sync tail. During all of that it holds an interrupt-block output high. Any other operation completes in its acceptance cycle.

The control state machine has four states:
- `ST_IDLE` accepts operations. A single-destination operation commits in place. A dual-destination operation moves on to `ST_DRAIN`.
- `ST_DRAIN` waits until no older instruction and no older CSR write is outstanding, then moves to `ST_EXEC`.
- `ST_EXEC` does the atomic read-modify-write and loads the tail counter, then moves to `ST_POST`.
- `ST_POST` counts the tail down and returns to `ST_IDLE` with `op_done` when the count reaches zero.

Top module: `csr_rmw_unit`

## Requirements
- R1: Swap (`op_kind` = 2'b01) writes the source value into the addressed CSR. It always writes, whatever the source index or immediate.
- R2: Set (`op_kind` = 2'b10) writes old OR source into the addressed CSR.
- R3: Clear (`op_kind` = 2'b11) writes old AND NOT source into the addressed CSR. Kind 2'b00 is read-only and never writes.
- R4: With `op_use_imm` = 1 the source is `op_uimm` zero-extended to XLEN bits. With `op_use_imm` = 0 the source is `op_rs1_val`.
- R5: In the commit cycle `rd_we` is high exactly when `op_rd_idx` is nonzero. `rd_idx` then equals `op_rd_idx`, and `rd_val` carries the CSR value from before the modification. With a destination of zero nothing is returned, but the CSR write still happens.
- R6: Set and clear perform no CSR write when the source is the zero index (register form, `op_rs1_idx` = 0) or a zero immediate. Only the read takes place.
- R7: An operation that is not dual-destination raises `op_done` and commits in its acceptance cycle, provided `older_csr_wr_pend` is low.
- R8: A dual-destination operation (it writes the CSR and has a nonzero destination) holds `irq_block` high from the cycle after acceptance until it completes. It commits only when `older_inflight` and `older_csr_wr_pend` are both low. With no stall, `op_done` arrives in the 8th cycle counted from acceptance; each added drain cycle adds one cycle.
- R9: No CSR read or write-back happens while `older_csr_wr_pend` is high.
- R10: Unimplemented addresses read as zero and ignore writes. Implemented addresses: status 0x300, scratch 0x340 and 0x341.
- R11: Only status bits 1 and 3 can be written; the other status bits read zero. `status_ie` shows status bit 1. A clear-immediate of 2 on the status register drops `status_ie` and returns the prior status, so a later swap can restore it.
- R12: After reset all CSRs read zero, and `op_done`, `irq_block` and `status_ie` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Operation present; fields held until `op_done` |
| op_kind | input | 2 | 00 read, 01 swap, 10 set, 11 clear |
| op_use_imm | input | 1 | Source is the immediate |
| op_csr | input | 12 | CSR address |
| op_rs1_idx | input | 5 | Source register index |
| op_rs1_val | input | XLEN | Source register value |
| op_uimm | input | 5 | Immediate source |
| op_rd_idx | input | 5 | Integer destination index |
| older_csr_wr_pend | input | 1 | An older CSR write is outstanding |
| older_inflight | input | 1 | Older instructions not yet drained |
| op_done | output | 1 | Operation completes this cycle |
| irq_block | output | 1 | Defer interrupt taking |
| rd_we | output | 1 | Integer write-back strobe |
| rd_idx | output | 5 | Integer write-back index |
| rd_val | output | XLEN | Old CSR value |
| status_ie | output | 1 | Interrupt enable from status bit 1 |

## Verification
The hardest cases to reach are the stalls. One is a dual-destination operation sitting in `ST_DRAIN` while `older_inflight` and `older_csr_wr_pend` drop at different cycles. The other is a single-destination operation held back by a pending older CSR write. To reach them, the bench drives the two stall inputs from per-cycle countdowns inside the operation task. It checks the cycle of the first write-back and the cycle of `op_done` against the closed-form timing of R7 and R8. A sweep over every address, kind, source form, zero or nonzero source and destination covers the arithmetic, with the bank contents read back after each operation.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;
    typedef enum logic [1:0] {
        K_READ = 2'b00,
        K_SWAP = 2'b01,
        K_SET  = 2'b10,
        K_CLR  = 2'b11
    } csr_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_EXEC,
        ST_POST
    } csr_st_e;
endpackage

// File: rtl/csr_rmw_alu.sv
module csr_rmw_alu #(
    parameter int XLEN = 32
) (
    input  logic [1:0]      kind,
    input  logic            use_imm,
    input  logic [4:0]      rs1_idx,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [4:0]      uimm,
    input  logic [XLEN-1:0] old_val,
    output logic [XLEN-1:0] new_val,
    output logic            wr_req
);
    import csr_rmw_pkg::*;

    logic [XLEN-1:0] src;
    logic            src_nz;

    assign src    = use_imm ? {{(XLEN-5){1'b0}}, uimm} : rs1_val;
    assign src_nz = use_imm ? (|uimm) : (|rs1_idx);

    always_comb begin
        new_val = old_val;
        wr_req  = 1'b0;
        unique case (csr_kind_e'(kind))
            K_SWAP: begin new_val = src;            wr_req = 1'b1;   end
            K_SET:  begin new_val = old_val | src;  wr_req = src_nz; end
            K_CLR:  begin new_val = old_val & ~src; wr_req = src_nz; end
            K_READ: begin new_val = old_val;        wr_req = 1'b0;   end
        endcase
    end
endmodule

// File: rtl/csr_rmw_bank.sv
module csr_rmw_bank #(
    parameter int          XLEN         = 32,
    parameter int          ADDR_W       = 12,
    parameter int          STATUS_ADDR  = 'h300,
    parameter int          SCR_BASE     = 'h340,
    parameter int          N_SCR        = 2,
    parameter int          IE_BIT       = 1,
    parameter logic [63:0] STATUS_WMASK = 64'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [XLEN-1:0]   rd_val,
    input  logic              we,
    input  logic [XLEN-1:0]   wr_val,
    output logic              ie
);
    localparam logic [XLEN-1:0]   WMASK = STATUS_WMASK[XLEN-1:0];
    localparam logic [ADDR_W-1:0] ST_A  = ADDR_W'(STATUS_ADDR);

    logic [XLEN-1:0] status_q;
    logic [XLEN-1:0] scr_q [N_SCR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  status_q <= '0;
        else if (we && addr == ST_A) status_q <= wr_val & WMASK;
    end

    for (genvar g = 0; g < N_SCR; g++) begin : g_scr
        localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(SCR_BASE + g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  scr_q[g] <= '0;
            else if (we && addr == MY_A) scr_q[g] <= wr_val;
        end
    end

    always_comb begin
        rd_val = '0;
        if (addr == ST_A) rd_val = status_q;
        for (int i = 0; i < N_SCR; i++)
            if (addr == ADDR_W'(SCR_BASE + i)) rd_val = scr_q[i];
    end

    assign ie = status_q[IE_BIT];
endmodule

// File: rtl/csr_rmw_ctrl.sv
module csr_rmw_ctrl #(
    parameter int POST_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic dual,
    input  logic older_csr_wr_pend,
    input  logic older_inflight,
    output logic commit,
    output logic op_done,
    output logic irq_block
);
    import csr_rmw_pkg::*;

    localparam int CW = $clog2(POST_CYCLES + 1);

    csr_st_e        st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           fast_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE:  if (op_valid && dual) st_d = ST_DRAIN;
            ST_DRAIN: if (!older_inflight && !older_csr_wr_pend) st_d = ST_EXEC;
            ST_EXEC: begin
                st_d  = ST_POST;
                cnt_d = CW'(POST_CYCLES - 1);
            end
            ST_POST: begin
                if (cnt_q == '0) st_d = ST_IDLE;
                else             cnt_d = cnt_q - CW'(1);
            end
        endcase
    end

    assign fast_go = (st_q == ST_IDLE) && op_valid && !dual && !older_csr_wr_pend;

    always_comb begin
        commit    = fast_go || (st_q == ST_EXEC);
        op_done   = fast_go || ((st_q == ST_POST) && (cnt_q == '0));
        irq_block = (st_q != ST_IDLE);
    end
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit #(
    parameter int          XLEN         = 32,
    parameter int          POST_CYCLES  = 5,
    parameter int          N_SCR        = 2,
    parameter int          STATUS_ADDR  = 'h300,
    parameter int          SCR_BASE     = 'h340,
    parameter logic [63:0] STATUS_WMASK = 64'hA
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [1:0]      op_kind,
    input  logic            op_use_imm,
    input  logic [11:0]     op_csr,
    input  logic [4:0]      op_rs1_idx,
    input  logic [XLEN-1:0] op_rs1_val,
    input  logic [4:0]      op_uimm,
    input  logic [4:0]      op_rd_idx,
    input  logic            older_csr_wr_pend,
    input  logic            older_inflight,
    output logic            op_done,
    output logic            irq_block,
    output logic            rd_we,
    output logic [4:0]      rd_idx,
    output logic [XLEN-1:0] rd_val,
    output logic            status_ie
);
    logic [XLEN-1:0] old_val, new_val;
    logic            wr_req, dual, commit;

    csr_rmw_bank #(
        .XLEN(XLEN), .ADDR_W(12), .STATUS_ADDR(STATUS_ADDR), .SCR_BASE(SCR_BASE),
        .N_SCR(N_SCR), .IE_BIT(1), .STATUS_WMASK(STATUS_WMASK)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .addr(op_csr), .rd_val(old_val),
        .we(commit && wr_req), .wr_val(new_val), .ie(status_ie)
    );

    csr_rmw_alu #(.XLEN(XLEN)) u_alu (
        .kind(op_kind), .use_imm(op_use_imm), .rs1_idx(op_rs1_idx),
        .rs1_val(op_rs1_val), .uimm(op_uimm), .old_val(old_val),
        .new_val(new_val), .wr_req(wr_req)
    );

    assign dual = wr_req && (op_rd_idx != 5'd0);

    csr_rmw_ctrl #(.POST_CYCLES(POST_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .dual(dual),
        .older_csr_wr_pend(older_csr_wr_pend), .older_inflight(older_inflight),
        .commit(commit), .op_done(op_done), .irq_block(irq_block)
    );

    assign rd_we  = commit && (op_rd_idx != 5'd0);
    assign rd_idx = op_rd_idx;
    assign rd_val = old_val;
endmodule

// File: rtl/csr_rmw_unit_chk.sv
module csr_rmw_unit_chk #(
    parameter int XLEN        = 32,
    parameter int STATUS_ADDR = 'h300,
    parameter int SCR_BASE    = 'h340,
    parameter int N_SCR       = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [11:0]     op_csr,
    input logic            older_csr_wr_pend,
    input logic            older_inflight,
    input logic            op_done,
    input logic            irq_block,
    input logic            rd_we,
    input logic [4:0]      rd_idx,
    input logic [XLEN-1:0] rd_val,
    input logic            status_ie
);
    logic impl;
    assign impl = (op_csr == 12'(STATUS_ADDR)) ||
                  ((op_csr >= 12'(SCR_BASE)) && (op_csr < 12'(SCR_BASE + N_SCR)));

    // R5
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> rd_idx != 5'd0);
    // R9
    pend_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> !older_csr_wr_pend);
    // R8
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we && irq_block) |-> !older_inflight);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we && irq_block) |=> irq_block);
    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && irq_block) |=> !irq_block);
    // R10
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we && !impl) |-> rd_val == '0);
    // R7
    done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> op_valid);
    // R11
    ie_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_ie) |-> $past(op_valid));
endmodule

bind csr_rmw_unit csr_rmw_unit_chk #(
    .XLEN(XLEN), .STATUS_ADDR(STATUS_ADDR), .SCR_BASE(SCR_BASE), .N_SCR(N_SCR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_csr(op_csr),
    .older_csr_wr_pend(older_csr_wr_pend), .older_inflight(older_inflight),
    .op_done(op_done), .irq_block(irq_block), .rd_we(rd_we), .rd_idx(rd_idx),
    .rd_val(rd_val), .status_ie(status_ie)
);

// File: tb/csr_rmw_unit_tb.sv
module csr_rmw_unit_tb;
    localparam int          XLEN  = 32;
    localparam logic [31:0] WMASK = 32'hA;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n;
    logic            op_valid, op_use_imm, older_csr_wr_pend, older_inflight;
    logic [1:0]      op_kind;
    logic [11:0]     op_csr;
    logic [4:0]      op_rs1_idx, op_uimm, op_rd_idx, rd_idx;
    logic [XLEN-1:0] op_rs1_val, rd_val;
    logic            op_done, irq_block, rd_we, status_ie;

    csr_rmw_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_use_imm(op_use_imm), .op_csr(op_csr), .op_rs1_idx(op_rs1_idx),
        .op_rs1_val(op_rs1_val), .op_uimm(op_uimm), .op_rd_idx(op_rd_idx),
        .older_csr_wr_pend(older_csr_wr_pend), .older_inflight(older_inflight),
        .op_done(op_done), .irq_block(irq_block), .rd_we(rd_we), .rd_idx(rd_idx),
        .rd_val(rd_val), .status_ie(status_ie)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] m_status, m_scr0, m_scr1;

    // result of the last operation
    bit          g_we;
    int          g_first_we;
    logic [31:0] g_val;
    logic [4:0]  g_idx;
    int          g_cyc;
    bit          g_irq0, g_irq_done;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    function automatic logic [31:0] mread(input logic [11:0] a);
        case (a)
            12'h300: return m_status;
            12'h340: return m_scr0;
            12'h341: return m_scr1;
            default: return 32'd0;
        endcase
    endfunction

    task automatic mwrite(input logic [11:0] a, input logic [31:0] v);
        case (a)
            12'h300: m_status = v & WMASK;
            12'h340: m_scr0 = v;
            12'h341: m_scr1 = v;
            default: ;
        endcase
    endtask

    task automatic do_op(input logic [1:0] k, input bit im, input logic [11:0] a,
                         input logic [4:0] ri, input logic [31:0] rv, input logic [4:0] ui,
                         input logic [4:0] rd, input int pend_c, input int busy_c);
        @(negedge clk);
        op_kind = k; op_use_imm = im; op_csr = a; op_rs1_idx = ri;
        op_rs1_val = rv; op_uimm = ui; op_rd_idx = rd; op_valid = 1'b1;
        g_we = 0; g_first_we = -1; g_cyc = 0; g_val = '0; g_idx = '0;
        for (int i = 0; i < 200; i++) begin
            older_csr_wr_pend = (i < pend_c);
            older_inflight    = (i < busy_c);
            #1;
            if (i == 0) g_irq0 = irq_block;
            if (rd_we && !g_we) begin
                g_we = 1; g_first_we = i; g_val = rd_val; g_idx = rd_idx;
            end
            g_cyc = i + 1;
            if (op_done) begin
                g_irq_done = irq_block;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        op_valid = 1'b0; older_csr_wr_pend = 1'b0; older_inflight = 1'b0;
    endtask

    function automatic string req_of(input logic [1:0] k, input bit wr);
        if (!wr && k != 2'b01) return (k == 2'b00) ? "R3" : "R6";
        case (k)
            2'b01: return "R1";
            2'b10: return "R2";
            default: return "R3";
        endcase
    endfunction

    // one checked operation against the model
    task automatic run(input logic [1:0] k, input bit im, input logic [11:0] a,
                       input logic [4:0] ri, input logic [31:0] rv, input logic [4:0] ui,
                       input logic [4:0] rd, input int pc, input int bc);
        logic [31:0] old, src, nv;
        bit wr, dual;
        int j, exp_cyc, exp_we;
        old = mread(a);
        src = im ? {27'd0, ui} : rv;
        wr  = (k == 2'b01) || (k != 2'b00 && (im ? (ui != 0) : (ri != 0)));
        case (k)
            2'b01:   nv = src;
            2'b10:   nv = old | src;
            2'b11:   nv = old & ~src;
            default: nv = old;
        endcase
        dual = wr && (rd != 0);
        j = 1;
        if (pc > j) j = pc;
        if (bc > j) j = bc;
        exp_cyc = dual ? j + 7 : pc + 1;
        exp_we  = dual ? j + 1 : pc;
        do_op(k, im, a, ri, rv, ui, rd, pc, bc);
        chk(g_we == (rd != 0), "R5 rd_we", 32'(g_we), 32'(rd != 0));
        if (rd != 0) begin
            chk(g_val == old, "R5 old value", g_val, old);
            chk(g_idx == rd, "R5 rd index", 32'(g_idx), 32'(rd));
            chk(g_first_we == exp_we, "R9 write-back cycle", 32'(g_first_we), 32'(exp_we));
        end
        chk(g_cyc == exp_cyc, dual ? "R8 latency" : "R7 latency", 32'(g_cyc), 32'(exp_cyc));
        if (dual) begin
            chk(!g_irq0 && g_irq_done, "R8 irq_block window",
                {30'd0, g_irq0, g_irq_done}, 32'd1);
        end
        if (wr) mwrite(a, nv);
        // read back through a read-only op (set, zero index)
        do_op(2'b10, 1'b0, a, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd1, 0, 0);
        chk(g_val == mread(a),
            (a == 12'h7C0) ? "R10 readback" : (im ? "R4 readback" : req_of(k, wr)),
            g_val, mread(a));
        chk(status_ie == m_status[1], "R11 status_ie", 32'(status_ie), 32'(m_status[1]));
    endtask

    initial begin
        logic [11:0] addrs [4];
        logic [4:0]  ui;
        logic [4:0]  ri;
        logic [31:0] rv;
        addrs[0] = 12'h300; addrs[1] = 12'h340; addrs[2] = 12'h341; addrs[3] = 12'h7C0;
        m_status = 0; m_scr0 = 0; m_scr1 = 0;
        rst_n = 1'b0; op_valid = 1'b0; op_kind = 0; op_use_imm = 0; op_csr = 0;
        op_rs1_idx = 0; op_rs1_val = 0; op_uimm = 0; op_rd_idx = 0;
        older_csr_wr_pend = 0; older_inflight = 0;
        repeat (3) @(negedge clk);
        #1;
        // R12 reset state
        chk(!op_done && !irq_block && !status_ie, "R12 reset outputs",
            {29'd0, op_done, irq_block, status_ie}, 32'd0);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            do_op(2'b00, 1'b0, addrs[a], 5'd0, 32'd0, 5'd0, 5'd2, 0, 0);
            chk(g_val == 32'd0, "R12 reset value", g_val, 32'd0);
        end

        // sweep: address x kind x source form x zero/nonzero source x destination
        for (int a = 0; a < 4; a++)
            for (int k = 0; k < 4; k++)
                for (int im = 0; im < 2; im++)
                    for (int z = 0; z < 2; z++)
                        for (int d = 0; d < 2; d++) begin
                            run(2'b01, 1'b0, addrs[a], 5'd4, 32'h0F0F_33C6 ^ 32'(k * 77 + a), 5'd0, 5'd3, 0, 0);
                            ui = (z == 0) ? 5'd0 : 5'(5'b01010 ^ 5'(k + d));
                            ri = (z == 0) ? 5'd0 : 5'd9;
                            rv = 32'hA5A5_5A5A ^ 32'(im * 1000 + a * 16 + k);
                            run(2'(k), 1'(im), addrs[a], ri, rv, ui, (d == 0) ? 5'd0 : 5'd7, 0, 0);
                        end

        // stalls: single-destination held back by pending CSR write (R7 R9)
        run(2'b10, 1'b1, 12'h341, 5'd0, 32'd0, 5'd3, 5'd0, 3, 0);
        run(2'b00, 1'b0, 12'h340, 5'd0, 32'd0, 5'd0, 5'd6, 4, 0);
        // dual-destination with drain and pending stalls in several overlaps (R8)
        run(2'b01, 1'b0, 12'h340, 5'd1, 32'hDEAD_BEEF, 5'd0, 5'd10, 0, 4);
        run(2'b11, 1'b1, 12'h340, 5'd0, 32'd0, 5'h0F, 5'd11, 6, 2);
        run(2'b10, 1'b0, 12'h341, 5'd2, 32'h0000_8001, 5'd0, 5'd12, 2, 7);
        run(2'b01, 1'b0, 12'h300, 5'd3, 32'hFFFF_FFFF, 5'd0, 5'd13, 1, 1);

        // R11 interrupt-enable save and restore sequence
        run(2'b01, 1'b0, 12'h300, 5'd5, 32'h0000_000A, 5'd0, 5'd0, 0, 0);
        chk(status_ie == 1'b1, "R11 ie set", 32'(status_ie), 32'd1);
        run(2'b11, 1'b1, 12'h300, 5'd0, 32'd0, 5'd2, 5'd5, 0, 0);
        chk(status_ie == 1'b0, "R11 ie cleared", 32'(status_ie), 32'd0);
        run(2'b01, 1'b0, 12'h300, 5'd5, 32'h0000_000A, 5'd0, 5'd0, 0, 0);
        chk(status_ie == 1'b1, "R11 ie restored", 32'(status_ie), 32'd1);

        finish_run();
    end
endmodule